// File: doc/BRIEF.md
# Bus Activity Monitor

The monitor watches one bus client. Every event pulse adds a programmable weight to a period accumulator. A millisecond tick input defines a sampling period, and that period can be programmed. At the end of each period the accumulated sample is taken and the accumulator restarts. The sample is compared against a raw upper and lower watermark. A breach only becomes an interrupt after a programmable number of consecutive periods on the same side of the band.

The sample also feeds an exponentially smoothed average. The smoothing window is a power of two. The updated average is compared against a second, separate pair of watermarks. All four results are latched into a status register with write-one-to-clear semantics. A single interrupt line is the OR of the status bits that are enabled. Software can preload the average and read it back.

Software sets the period, the watermarks, the weight and the control word through a simple register bus. Reads on that bus are combinational. Software then reacts to the interrupt by adjusting the watermarks or the clock rate outside this block.

Top module: `bus_activity_mon`

## Requirements
- R1: After reset, the control word, the average, the watermarks and the status all read 0, and irq is 0. The period register (index 1) reads 11, which gives 12 ticks. The weight register (index 7) reads 1024.
- R2: When control bit 31 (run) and bit 18 (periodic) are both set, a period ends on the tick that brings the tick count to the period register value plus one.
- R3: Each cycle with event_in high while running adds the weight (index 7) to the period sample. The sample saturates at all ones.
- R4: At each period end, the average (read at index 8) becomes avg + ((sample − avg) >>> (K+1)) using signed arithmetic. K is control bits [12:10].
- R5: A write to index 4 loads the average directly. This write takes precedence over a period update in the same cycle.
- R6: A sample strictly above the upper watermark (index 2) in N consecutive periods sets status bit 31 once and restarts the run. N is control bits [28:26] plus 1. A period that is not above the watermark zeroes the run.
- R7: A sample strictly below the lower watermark (index 3) in M consecutive periods sets status bit 30 once and restarts the run. M is control bits [25:23] plus 1. A period that is not below the watermark zeroes the run.
- R8: At a period end, an updated average strictly above index 5 sets status bit 29. An updated average strictly below index 6 sets status bit 28.
- R9: Writing index 9 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R10: irq is high when at least one of the following pairs is set together:
  - status 31 and control bit 30
  - status 30 and control bit 29
  - status 29 and control bit 21
  - status 28 and control bit 20
- R11: While run is 0, events and ticks are ignored, and the average and status keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| event_in | input | 1 | One weighted bus event per high cycle |
| ms_tick | input | 1 | Millisecond tick |
| irq | output | 1 | Enabled status OR |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and an 8-bit tick counter. It then programs a three-tick period and a weight of 16, so each period lasts only a few dozen cycles. Random event counts, window exponents of 0 to 3 and breach counts of 1 to 3 drive both consecutive runs through their limits and reset them. A weight near full scale brings the saturating sample into reach, and the average then moves halfway towards all ones.

// File: rtl/bus_activity_mon.sv
`timescale 1ns/1ps
module bus_activity_mon #(
  parameter int DW         = 32,
  parameter int AW         = 4,
  parameter int PER_W      = 8,
  parameter int PERIOD_RST = 11,
  parameter int WEIGHT_RST = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          event_in,
  input  logic          ms_tick,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_PER = AW'(1), A_UP = AW'(2),
    A_LO = AW'(3), A_INIT = AW'(4), A_AUP = AW'(5), A_ALO = AW'(6),
    A_WGT = AW'(7), A_AVG = AW'(8), A_STAT = AW'(9);

  logic [DW-1:0]    ctrl_q, up_wm, lo_wm, aup_wm, alo_wm, weight_q, avg_q, acc_q;
  logic [PER_W-1:0] period_q, ms_q;
  logic [2:0]       up_run, lo_run;
  logic [3:0]       status_q;

  wire run      = ctrl_q[31];
  wire periodic = ctrl_q[18];
  wire [2:0] k  = ctrl_q[12:10];

  wire [DW:0]   acc_sum = {1'b0, acc_q} + (event_in ? {1'b0, weight_q} : '0);
  wire [DW-1:0] acc_nxt = acc_sum[DW] ? '1 : acc_sum[DW-1:0];
  wire          pend    = run && periodic && ms_tick && (ms_q >= period_q);

  wire signed [DW:0] diff = $signed({1'b0, acc_nxt}) - $signed({1'b0, avg_q});
  wire signed [DW:0] step = diff >>> ({1'b0, k} + 4'd1);
  wire [DW:0]        avg_w = {1'b0, avg_q} + step;
  wire [DW-1:0]      avg_upd = avg_w[DW-1:0];

  wire above  = acc_nxt > up_wm;
  wire below  = acc_nxt < lo_wm;
  wire hit_up = above && (up_run == ctrl_q[28:26]);
  wire hit_lo = below && (lo_run == ctrl_q[25:23]);

  wire [3:0] st_set = pend ? {hit_up, hit_lo, avg_upd > aup_wm, avg_upd < alo_wm} : 4'b0;
  wire [3:0] st_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[DW-1:DW-4] : 4'b0;
  wire [3:0] st_en  = {ctrl_q[30], ctrl_q[29], ctrl_q[21], ctrl_q[20]};

  assign irq = |(status_q & st_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; up_wm <= '0; lo_wm <= '0; aup_wm <= '0; alo_wm <= '0;
      weight_q <= DW'(WEIGHT_RST); period_q <= PER_W'(PERIOD_RST);
      avg_q <= '0; acc_q <= '0; ms_q <= '0;
      up_run <= '0; lo_run <= '0; status_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: ctrl_q   <= bus_wdata;
          A_PER:  period_q <= bus_wdata[PER_W-1:0];
          A_UP:   up_wm    <= bus_wdata;
          A_LO:   lo_wm    <= bus_wdata;
          A_AUP:  aup_wm   <= bus_wdata;
          A_ALO:  alo_wm   <= bus_wdata;
          A_WGT:  weight_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_wr && bus_addr == A_INIT) avg_q <= bus_wdata;
      else if (pend)                    avg_q <= avg_upd;
      if (run) acc_q <= pend ? '0 : acc_nxt;
      if (run && periodic && ms_tick) ms_q <= pend ? '0 : ms_q + 1'b1;
      if (pend) begin
        up_run <= (above && !hit_up) ? up_run + 3'd1 : 3'd0;
        lo_run <= (below && !hit_lo) ? lo_run + 3'd1 : 3'd0;
      end
      status_q <= (status_q & ~st_clr) | st_set;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:        bus_rdata = ctrl_q;
      A_PER:         bus_rdata = DW'(period_q);
      A_UP:          bus_rdata = up_wm;
      A_LO:          bus_rdata = lo_wm;
      A_INIT, A_AVG: bus_rdata = avg_q;
      A_AUP:         bus_rdata = aup_wm;
      A_ALO:         bus_rdata = alo_wm;
      A_WGT:         bus_rdata = weight_q;
      A_STAT:        bus_rdata = {status_q, {(DW-4){1'b0}}};
      default:       bus_rdata = '0;
    endcase
  end

  // R11: no average movement while stopped unless software preloads it
  a_r11_hold_avg: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(bus_wr && bus_addr == A_INIT)) |=> $stable(avg_q));
  // R2: accumulator restarts after a period end
  a_r2_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (acc_q == '0));
  // R6: the above-run restarts when its flag is raised
  a_r6_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[3]) |-> (up_run == 3'd0));
  // R9: written ones clear unless a period end re-sets them
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && !pend) |=> ((status_q & $past(bus_wdata[DW-1:DW-4])) == 4'b0));
  // R10: interrupt only with some status pending
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != 4'b0));
endmodule

// File: tb/bus_activity_mon_test.sv
`timescale 1ns/1ps
module bus_activity_mon_test;
  localparam int PER = 2;
  localparam longint MAXV = 64'hFFFF_FFFF;

  logic clk = 0, rst_n = 0, bus_wr = 0, ev = 0, tick = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  longint m_avg, m_up, m_lo, m_aup, m_alo, m_wgt;
  logic [31:0] m_ctrl;
  int m_upr, m_lor;
  logic [3:0] m_st;

  bus_activity_mon uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_in(ev), .ms_tick(tick), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic run_period(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); ev = 1; tick = 0; end
    for (int i = 0; i <= PER; i++) begin @(negedge clk); ev = 0; tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  function automatic logic model_irq();
    return |(m_st & {m_ctrl[30], m_ctrl[29], m_ctrl[21], m_ctrl[20]});
  endfunction

  task automatic model_period(int n);
    longint s = longint'(n) * m_wgt;
    longint d, st;
    logic a, b, hu, hl;
    if (s > MAXV) s = MAXV;
    a = s > m_up; b = s < m_lo;
    hu = a && (m_upr == int'(m_ctrl[28:26]));
    hl = b && (m_lor == int'(m_ctrl[25:23]));
    d = s - m_avg;
    st = d >>> (int'(m_ctrl[12:10]) + 1);
    m_avg = (m_avg + st) & MAXV;
    m_upr = (a && !hu) ? m_upr + 1 : 0;
    m_lor = (b && !hl) ? m_lor + 1 : 0;
    m_st = m_st | {hu, hl, m_avg > m_aup, m_avg < m_alo};
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(4'd8, v); check({"R4 avg ", tag}, v, m_avg);
    rd(4'd9, v); check({"R6/R7/R8 status ", tag}, v[31:28], m_st);
    check({"R10 irq ", tag}, irq, model_irq());
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 0);
    rd(4'd1, v); check("R1 period", v, 11);
    rd(4'd7, v); check("R1 weight", v, 1024);
    rd(4'd8, v); check("R1 avg", v, 0);
    rd(4'd9, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);

    m_wgt = 16; m_up = 400; m_lo = 100; m_aup = 500; m_alo = 200;
    m_avg = 0; m_upr = 0; m_lor = 0; m_st = 0;
    wr(4'd1, PER); wr(4'd7, 16); wr(4'd2, 400); wr(4'd3, 100);
    wr(4'd5, 500); wr(4'd6, 200);
    // R5 preload
    wr(4'd4, 1000); m_avg = 1000;
    rd(4'd8, v); check("R5 preload", v, 1000);

    // R11 stopped: periodic set but run clear
    m_ctrl = 32'h0004_0000; wr(4'd0, m_ctrl);
    run_period(20); run_period(5);
    rd(4'd8, v); check("R11 avg held", v, 1000);
    rd(4'd9, v); check("R11 status held", v, 0);

    // R2/R3/R4 directed: K=0, 5 events, sample 80, avg = 1000 + (80-1000)>>>1 = 540
    m_ctrl = 32'h8004_0000; wr(4'd0, m_ctrl);
    run_period(5); model_period(5);
    rd(4'd8, v); check("R2/R3/R4 first period avg", v, 540);
    check_all("directed");

    // R9 partial clear
    wr(4'd9, 32'h1000_0000); m_st &= 4'b1110;
    rd(4'd9, v); check("R9 partial clear", v[31:28], m_st);
    wr(4'd9, 32'hFFFF_FFFF); m_st = 0;
    rd(4'd9, v); check("R9 full clear", v, 0);

    // R6 directed: N=2 above, enabled
    m_ctrl = 32'hC004_0000 | (32'd1 << 26); wr(4'd0, m_ctrl);
    run_period(30); model_period(30);
    rd(4'd9, v); check("R6 first above no flag", v[31], 0);
    run_period(30); model_period(30);
    rd(4'd9, v); check("R6 second above flags", v[31], 1);
    check("R10 irq above", irq, 1);
    wr(4'd9, 32'h8000_0000); m_st[3] = 0;
    run_period(30); model_period(30);
    rd(4'd9, v); check("R6 run restarted", v[31], 0);
    check_all("r6");

    // R7 directed: M=3 below, in-band period breaks the run
    wr(4'd9, 32'hFFFF_FFFF); m_st = 0;
    m_ctrl = 32'hA004_0000 | (32'd2 << 23); wr(4'd0, m_ctrl);
    run_period(2); model_period(2);
    run_period(2); model_period(2);
    run_period(10); model_period(10);
    run_period(2); model_period(2);
    rd(4'd9, v); check("R7 broken run no flag", v[30], 0);
    run_period(2); model_period(2);
    run_period(2); model_period(2);
    rd(4'd9, v); check("R7 three below flags", v[30], 1);
    check_all("r7");

    // random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(0, 5) == 0) begin
        m_ctrl = 32'h8004_0000 | ($urandom & 32'h6030_0000)
               | (32'($urandom_range(0, 3)) << 10)
               | (32'($urandom_range(0, 2)) << 23) | (32'($urandom_range(0, 2)) << 26);
        wr(4'd0, m_ctrl);
      end
      if ($urandom_range(0, 4) == 0) begin
        v = $urandom & 32'hF000_0000;
        wr(4'd9, v); m_st &= ~v[31:28];
      end
      begin
        int n = $urandom_range(0, 40);
        run_period(n); model_period(n);
      end
      check_all("random");
    end

    // R10 masking: status pending, all enables off
    m_ctrl = 32'h8004_0000; wr(4'd0, m_ctrl);
    run_period(40); model_period(40);
    check("R10 masked irq", irq, 0);

    // R3 saturation: K=0, huge weight
    wr(4'd9, 32'hFFFF_FFFF); m_st = 0;
    wr(4'd4, 0); m_avg = 0;
    wr(4'd7, 32'hFFFF_FFF0); m_wgt = 64'hFFFF_FFF0;
    run_period(3); model_period(3);
    rd(4'd8, v); check("R3 saturated sample", v, 32'h7FFF_FFFF);
    check_all("sat");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule